// File: doc/BRIEF.md
# Scanline Blanking Timer with DMA Triggers

This block keeps track of where the display scan is on a 240 by 160 screen and turns that position into the blanking status bits and the strobes that start blanking-synchronised DMA transfers. A per-cycle enable advances a cycle counter inside the current line. Each line has a visible part of 960 cycles followed by 272 cycles of horizontal blank, for 1232 cycles in all. The line counter runs from 0 to 227 and then wraps to 0.

When a line reaches horizontal blank, the hblank bit rises. An HBlank DMA request is issued at the same moment, but only if the vblank bit is clear. When the scan advances from line 159 to line 160, the vblank bit rises. That same step issues a VBlank DMA request and a strobe that tells both affine backgrounds to latch their reference points. The vblank bit falls when the line counter reaches 227. As a result, the last line of the frame raises an HBlank DMA request again.

All outputs are registered. Each strobe is one clock wide. The DMA engines, rendering and interrupt logic sit outside this block and consume its outputs.

Top module: `blank_dma_trigger`

## Requirements
- R1: While reset is high and in the first cycle after it, scanline is 0 and hblank, vblank and all three strobes are 0.
- R2: A clock edge with tick_en low changes nothing: scanline and both status bits hold, and no strobe fires.
- R3: hblank becomes 1 on the enabled tick that completes cycle 959 of a line (960 visible cycles), and returns to 0 on the tick that starts the next line.
- R4: After 1232 enabled ticks the scanline advances by one. From 227 it wraps to 0.
- R5: vblank becomes 1 in the same cycle that scanline changes from 159 to 160.
- R6: vblank becomes 0 in the same cycle that scanline changes to 227.
- R7: hblank_dma_req pulses in the cycle hblank rises, but only when vblank is 0 at that point. This gives lines 0 to 159 and line 227 a pulse, and lines 160 to 226 none.
- R8: vblank_dma_req pulses in the cycle vblank rises, once per frame.
- R9: affine_ref_latch pulses in exactly the cycles where vblank_dma_req pulses.
- R10: Every strobe is high for exactly one clock per event and is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the in-line cycle counter by one |
| scanline | output | 8 | Current line number, 0 to 227 |
| hblank | output | 1 | Horizontal blank status |
| vblank | output | 1 | Vertical blank status |
| hblank_dma_req | output | 1 | One-clock HBlank DMA request |
| vblank_dma_req | output | 1 | One-clock VBlank DMA request |
| affine_ref_latch | output | 1 | One-clock strobe to latch affine reference points |

## Verification
The bench shrinks the line and frame sizes through the parameters and compares every output against a behavioural model on each clock. It uses four stimulus patterns:
- A continuously high enable checks the exact cycle on which each event lands.
- A sparse random enable shows whether the design counts ticks or counts clocks.
- A long stall with the enable low separates "holds" from "drifts" and catches strobes that repeat while the counter stands still.
- A reset in the middle of a frame shows that every flag and counter returns to its starting state.

Per-frame pulse counts tell the suppressed vblank lines apart from the final line, where HBlank DMA becomes possible again.

// File: rtl/blank_pkg.sv
package blank_pkg;
  // Events decoded from the in-line cycle counter on an enabled tick.
  typedef struct packed {
    logic vis_end;   // last visible cycle completes
    logic line_end;  // last cycle of the line completes
  } line_evt_t;
endpackage

// File: rtl/line_cycle_counter.sv
module line_cycle_counter #(
  parameter int VIS_CYC  = 960,
  parameter int LINE_CYC = 1232
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  output blank_pkg::line_evt_t  evt
);
  localparam int DW = $clog2(LINE_CYC);

  logic [DW-1:0] dot;

  always_comb begin
    evt.vis_end  = tick_en && (dot == DW'(VIS_CYC - 1));
    evt.line_end = tick_en && (dot == DW'(LINE_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst)               dot <= '0;
    else if (evt.line_end) dot <= '0;
    else if (tick_en)      dot <= dot + DW'(1);
  end

  // R3/R4: the two events never coincide
  a_r3_events_distinct: assert property (@(posedge clk) disable iff (rst)
    !(evt.vis_end && evt.line_end));
endmodule

// File: rtl/scanline_counter.sv
module scanline_counter #(
  parameter int V_TOTAL = 228,
  localparam int LW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  output logic [LW-1:0] line
);
  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else if (line_end)
      line <= (line == LW'(V_TOTAL - 1)) ? '0 : line + LW'(1);
  end

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (line == '0) && (line != $past(line)) |-> $past(line) == LW'(V_TOTAL - 1));
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (line != '0) && (line != $past(line)) |-> line == $past(line) + LW'(1));
endmodule

// File: rtl/blank_flags.sv
module blank_flags #(
  parameter int V_VISIBLE = 160,
  parameter int V_TOTAL   = 228,
  localparam int LW = $clog2(V_TOTAL)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  blank_pkg::line_evt_t evt,
  input  logic [LW-1:0]        line,
  output logic                 hblank,
  output logic                 vblank,
  output logic                 hdma_req,
  output logic                 vdma_req,
  output logic                 ref_latch
);
  logic enter_vbl, leave_vbl;

  // Entering line V_VISIBLE sets vblank; entering the last line clears it.
  assign enter_vbl = evt.line_end && (line == LW'(V_VISIBLE - 1));
  assign leave_vbl = evt.line_end && (line == LW'(V_TOTAL - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      hblank    <= 1'b0;
      vblank    <= 1'b0;
      hdma_req  <= 1'b0;
      vdma_req  <= 1'b0;
      ref_latch <= 1'b0;
    end else begin
      if (evt.line_end)     hblank <= 1'b0;
      else if (evt.vis_end) hblank <= 1'b1;
      if (enter_vbl)        vblank <= 1'b1;
      else if (leave_vbl)   vblank <= 1'b0;
      hdma_req  <= evt.vis_end && !vblank;
      vdma_req  <= enter_vbl;
      ref_latch <= enter_vbl;
    end
  end

  a_r7_hdma_outside_vbl: assert property (@(posedge clk) disable iff (rst)
    hdma_req |-> !vblank);
  a_r7_hdma_on_hbl_rise: assert property (@(posedge clk) disable iff (rst)
    hdma_req |-> $rose(hblank));
  a_r8_vdma_on_vbl_rise: assert property (@(posedge clk) disable iff (rst)
    vdma_req |-> $rose(vblank));
  a_r10_hdma_one_wide: assert property (@(posedge clk) disable iff (rst)
    hdma_req |=> !hdma_req);
  a_r10_vdma_one_wide: assert property (@(posedge clk) disable iff (rst)
    vdma_req |=> !vdma_req);
endmodule

// File: rtl/blank_dma_trigger.sv
module blank_dma_trigger #(
  parameter int H_VISIBLE_PX = 240,
  parameter int CYC_PER_PX   = 4,
  parameter int H_BLANK_CYC  = 272,
  parameter int V_VISIBLE    = 160,
  parameter int V_TOTAL      = 228,
  localparam int LW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  output logic [LW-1:0] scanline,
  output logic          hblank,
  output logic          vblank,
  output logic          hblank_dma_req,
  output logic          vblank_dma_req,
  output logic          affine_ref_latch
);
  localparam int VIS_CYC  = H_VISIBLE_PX * CYC_PER_PX;
  localparam int LINE_CYC = VIS_CYC + H_BLANK_CYC;

  blank_pkg::line_evt_t evt;

  line_cycle_counter #(.VIS_CYC(VIS_CYC), .LINE_CYC(LINE_CYC)) u_dot (
    .clk(clk), .rst(rst), .tick_en(tick_en), .evt(evt)
  );

  scanline_counter #(.V_TOTAL(V_TOTAL)) u_line (
    .clk(clk), .rst(rst), .line_end(evt.line_end), .line(scanline)
  );

  blank_flags #(.V_VISIBLE(V_VISIBLE), .V_TOTAL(V_TOTAL)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .line(scanline),
    .hblank(hblank), .vblank(vblank), .hdma_req(hblank_dma_req),
    .vdma_req(vblank_dma_req), .ref_latch(affine_ref_latch)
  );

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(scanline) && $stable(hblank) && $stable(vblank)
                 && !hblank_dma_req && !vblank_dma_req && !affine_ref_latch);
  a_r5_vbl_set_line: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> scanline == LW'(V_VISIBLE));
  a_r6_vbl_clear_line: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank) |-> scanline == LW'(V_TOTAL - 1));
  a_r9_latch_with_vdma: assert property (@(posedge clk) disable iff (rst)
    affine_ref_latch |-> vblank_dma_req && $rose(vblank));
  a_r3_hbl_clear_newline: assert property (@(posedge clk) disable iff (rst)
    $fell(hblank) |-> scanline != $past(scanline));
endmodule

// File: tb/test_blank_dma_trigger.sv
module test_blank_dma_trigger;
  localparam int HPX = 3, CPP = 2, HBL = 3, VV = 4, VT = 7;
  localparam int VIS = HPX * CPP, LINE = VIS + HBL;

  logic clk = 0, rst = 1, tick_en = 0;
  logic [2:0] scanline;
  logic hblank, vblank, hdma, vdma, latch;

  always #4 clk = ~clk;  // 125 MHz

  blank_dma_trigger #(.H_VISIBLE_PX(HPX), .CYC_PER_PX(CPP), .H_BLANK_CYC(HBL),
    .V_VISIBLE(VV), .V_TOTAL(VT)) i_blank_dma_trigger (
    .clk(clk), .rst(rst), .tick_en(tick_en), .scanline(scanline),
    .hblank(hblank), .vblank(vblank), .hblank_dma_req(hdma),
    .vblank_dma_req(vdma), .affine_ref_latch(latch));

  int checks = 0, errors = 0;
  int m_dot = 0, m_line = 0, m_hb = 0, m_vb = 0, m_eh = 0, m_ev = 0;
  int n_hdma = 0, n_vdma = 0;
  logic prev_h = 0, prev_v = 0, prev_l = 0;
  bit cmp_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_dot = 0; m_line = 0; m_hb = 0; m_vb = 0; m_eh = 0; m_ev = 0;
    end else begin
      m_eh = 0; m_ev = 0;
      if (tick_en) begin
        if (m_dot == VIS - 1) begin m_hb = 1; m_eh = (m_vb == 0); end
        if (m_dot == LINE - 1) begin
          m_dot = 0; m_hb = 0;
          m_line = (m_line + 1) % VT;
          if (m_line == VV) begin m_vb = 1; m_ev = 1; end
          if (m_line == VT - 1) m_vb = 0;
        end else m_dot++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk(scanline == m_line, "R4 scanline", scanline, m_line);
      chk(hblank == m_hb, "R3 hblank", hblank, m_hb);
      chk(vblank == m_vb, "R5/R6 vblank", vblank, m_vb);
      chk(hdma == m_eh, "R7 hdma", hdma, m_eh);
      chk(vdma == m_ev, "R8 vdma", vdma, m_ev);
      chk(latch == m_ev, "R9 latch", latch, m_ev);
      chk(!(prev_h && hdma) && !(prev_v && vdma) && !(prev_l && latch),
          "R10 one-wide", {prev_h & hdma, prev_v & vdma}, 0);
      n_hdma += hdma; n_vdma += vdma;
    end
    prev_h = hdma; prev_v = vdma; prev_l = latch;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scanline == 0 && !hblank && !vblank && !hdma && !vdma && !latch,
        "R1 reset", {scanline, hblank, vblank, hdma, vdma, latch}, 0);
    rst = 0;
    @(negedge clk);
    chk(scanline == 0 && !hblank && !vblank && !hdma && !vdma && !latch,
        "R1 after reset", {scanline, hblank, vblank, hdma, vdma, latch}, 0);
    cmp_en = 1;
    // continuous enable, three frames
    n_hdma = 0; n_vdma = 0;
    tick_en = 1;
    repeat (3 * LINE * VT) @(negedge clk);
    chk(n_hdma == 3 * (VV + 1), "R7 hdma per frame", n_hdma, 3 * (VV + 1));
    chk(n_vdma == 3, "R8 vdma per frame", n_vdma, 3);
    // R2: long stall mid-line
    repeat (5) @(negedge clk);
    tick_en = 0;
    begin
      logic [2:0] l0 = scanline;
      logic hb0 = hblank, vb0 = vblank;
      repeat (40) @(negedge clk);
      chk(scanline == l0 && hblank == hb0 && vblank == vb0,
          "R2 stall holds", {scanline, hblank, vblank}, {l0, hb0, vb0});
    end
    // sparse random enable
    for (int i = 0; i < 1500; i++) begin
      tick_en = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    // reset mid-frame
    tick_en = 1;
    repeat (17) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk(scanline == 0 && !hblank && !vblank && !hdma,
        "R1 mid-run reset", {scanline, hblank, vblank, hdma}, 0);
    rst = 0;
    for (int i = 0; i < 2 * LINE * VT; i++) begin
      tick_en = $urandom_range(0, 1);
      @(negedge clk);
    end
    summary();
  end
endmodule